// File: doc/BRIEF.md
# Dual-Phase Serial Audio Frame Serializer

This block turns a stream of parallel PCM words into a serial data line for an audio link. It runs on the system clock and moves one bit for every bit-clock enable pulse, which marks the bit-clock edge on which transmit data changes. A frame-sync input, sampled on those same pulses, starts each frame. A frame holds one or two phases. Each phase has its own word count and word length. This covers both the two-slot left/right layout of I2S stereo and the packed single-phase multichannel layout of DSP-style links.

Placement of the first data bit is configurable. With a data delay of one, the frame-sync tick carries a zero and the first data bit follows on the next tick, as I2S and DSP-A framing require. With a delay of zero, the first data bit goes out on the frame-sync tick itself, as DSP-B framing requires. Words are taken from a valid/ready source, one word at the start of each slot. Missing words are replaced by zeros and reported. Frame-sync polarity and the bit-clock divider sit outside this block.

Top module: `serial_frame_tx`

## Requirements
- R1: While reset is asserted and just after it, `sdata`, `wr_ready` and `underrun` are all 0.
- R2: `sdata` changes only on the clock edge of a cycle in which `bclk_en` is 1.
- R3: When `cfg_delay1` is 1, the tick that samples `fsync`=1 drives 0 and the first data bit follows on the next tick. When `cfg_delay1` is 0, the first data bit is driven on the `fsync` tick itself.
- R4: Each word is sent most significant bit first. The length field holds bit count minus 1, and the word occupies the low (length) bits of `wr_data`, starting at bit index length-minus-1.
- R5: With `cfg_dual_phase`=0, the frame carries `cfg_ph1_words_m1`+1 words of length `cfg_ph1_len_m1`+1, back to back.
- R6: With `cfg_dual_phase`=1, phase 2 follows phase 1 immediately and carries `cfg_ph2_words_m1`+1 words of length `cfg_ph2_len_m1`+1. Stereo I2S uses one word in each phase.
- R7: After the last word of a frame, and from reset until the first `fsync`, `sdata` is 0 and no word is requested.
- R8: `wr_ready` is 1 only in a `bclk_en` cycle that starts a slot, so exactly one word is taken per slot (taken when `wr_valid` and `wr_ready` are both 1).
- R9: If `wr_valid` is 0 when a slot starts, that slot shifts out zeros and `underrun` is 1 for the following clock cycle.
- R10: An `fsync` tick in the middle of a frame abandons the current word and restarts the frame at phase 1, word 0, honouring the data delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bclk_en | input | 1 | One-cycle pulse at each transmit bit-clock edge |
| fsync | input | 1 | Frame start, sampled when `bclk_en` is 1 |
| cfg_dual_phase | input | 1 | 1: frame has two phases |
| cfg_delay1 | input | 1 | 1: one-bit data delay after frame sync |
| cfg_ph1_words_m1 | input | 4 | Phase 1 words minus 1 |
| cfg_ph2_words_m1 | input | 4 | Phase 2 words minus 1 |
| cfg_ph1_len_m1 | input | 4 | Phase 1 word length minus 1 |
| cfg_ph2_len_m1 | input | 4 | Phase 2 word length minus 1 |
| wr_valid | input | 1 | A word is offered |
| wr_data | input | 16 | Offered word, right-aligned |
| wr_ready | output | 1 | Word taken this cycle |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Pulse: a slot started without a word |

## Verification
A wrong slot or phase state appears at `sdata` as a misplaced bit. Because every bit is compared against an independently built frame, the mismatch is seen on the very tick where the state diverges. A wrong word counter also shows up in the number of `wr_ready` handshakes per frame, and a bad delay state moves the whole frame by exactly one tick. Loss of the idle state shows as non-zero bits or extra requests after the frame tail, which are visible within one tick of the last word.

// File: rtl/serial_frame_tx_pkg.sv
package serial_frame_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_SHIFT = 2'd2
  } frame_state_t;
endpackage

// File: rtl/frame_slot_ctrl.sv
module frame_slot_ctrl
  import serial_frame_tx_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             fsync,
  input  logic             dual_phase,
  input  logic             delay1,
  input  logic [CNT_W-1:0] ph1_words_m1,
  input  logic [CNT_W-1:0] ph2_words_m1,
  input  logic [LEN_W-1:0] ph1_len_m1,
  input  logic [LEN_W-1:0] ph2_len_m1,
  input  logic             last_bit,
  output logic             slot_start,
  output logic             drive_zero,
  output logic [LEN_W-1:0] slot_len_m1
);
  frame_state_t     st_q, st_n;
  logic             phase_q, phase_n;
  logic [CNT_W-1:0] widx_q, widx_n;
  logic [CNT_W-1:0] words_m1;

  assign words_m1    = phase_q ? ph2_words_m1 : ph1_words_m1;
  assign slot_len_m1 = phase_n ? ph2_len_m1 : ph1_len_m1;

  always_comb begin
    st_n       = st_q;
    phase_n    = phase_q;
    widx_n     = widx_q;
    slot_start = 1'b0;
    drive_zero = 1'b0;
    if (tick) begin
      if (fsync) begin
        phase_n = 1'b0;
        widx_n  = '0;
        if (delay1) begin
          st_n       = ST_DELAY;
          drive_zero = 1'b1;
        end else begin
          st_n       = ST_SHIFT;
          slot_start = 1'b1;
        end
      end else begin
        case (st_q)
          ST_DELAY: begin
            st_n       = ST_SHIFT;
            slot_start = 1'b1;
          end
          ST_SHIFT: begin
            if (last_bit) begin
              if (widx_q != words_m1) begin
                widx_n     = widx_q + 1'b1;
                slot_start = 1'b1;
              end else if (!phase_q && dual_phase) begin
                phase_n    = 1'b1;
                widx_n     = '0;
                slot_start = 1'b1;
              end else begin
                st_n       = ST_IDLE;
                drive_zero = 1'b1;
              end
            end
          end
          default: drive_zero = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      phase_q <= 1'b0;
      widx_q  <= '0;
    end else if (tick) begin
      st_q    <= st_n;
      phase_q <= phase_n;
      widx_q  <= widx_n;
    end
  end
endmodule

// File: rtl/word_bit_shifter.sv
module word_bit_shifter #(
  parameter int WORD_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              slot_start,
  input  logic              drive_zero,
  input  logic [LEN_W-1:0]  slot_len_m1,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              sdata,
  output logic              last_bit,
  output logic              underrun
);
  logic [WORD_W-1:0] word_q, word_n;
  logic [LEN_W-1:0]  cnt_q, cnt_n, cnt_dec;
  logic              sd_q, sd_n;
  logic              urun_q, urun_n;

  assign cnt_dec = cnt_q - 1'b1;

  always_comb begin
    word_n = word_q;
    cnt_n  = cnt_q;
    sd_n   = sd_q;
    urun_n = slot_start & ~wr_valid;
    if (tick) begin
      if (slot_start) begin
        word_n = wr_valid ? wr_data : '0;
        cnt_n  = slot_len_m1;
        sd_n   = word_n[slot_len_m1];
      end else if (drive_zero) begin
        sd_n = 1'b0;
      end else if (cnt_q != '0) begin
        cnt_n = cnt_dec;
        sd_n  = word_q[cnt_dec];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
      sd_q   <= 1'b0;
      urun_q <= 1'b0;
    end else begin
      urun_q <= urun_n;
      if (tick) begin
        word_q <= word_n;
        cnt_q  <= cnt_n;
        sd_q   <= sd_n;
      end
    end
  end

  assign sdata    = sd_q;
  assign last_bit = (cnt_q == '0);
  assign underrun = urun_q;
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 16,
  localparam int LEN_W    = $clog2(WORD_W),
  localparam int CNT_W    = $clog2(MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_en,
  input  logic              fsync,
  input  logic              cfg_dual_phase,
  input  logic              cfg_delay1,
  input  logic [CNT_W-1:0]  cfg_ph1_words_m1,
  input  logic [CNT_W-1:0]  cfg_ph2_words_m1,
  input  logic [LEN_W-1:0]  cfg_ph1_len_m1,
  input  logic [LEN_W-1:0]  cfg_ph2_len_m1,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              sdata,
  output logic              underrun
);
  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  logic             slot_start, drive_zero, last_bit;
  logic [LEN_W-1:0] slot_len_m1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  frame_slot_ctrl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) i_ctrl (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .tick         (bclk_en & core_rst_n),
    .fsync        (fsync),
    .dual_phase   (cfg_dual_phase),
    .delay1       (cfg_delay1),
    .ph1_words_m1 (cfg_ph1_words_m1),
    .ph2_words_m1 (cfg_ph2_words_m1),
    .ph1_len_m1   (cfg_ph1_len_m1),
    .ph2_len_m1   (cfg_ph2_len_m1),
    .last_bit     (last_bit),
    .slot_start   (slot_start),
    .drive_zero   (drive_zero),
    .slot_len_m1  (slot_len_m1)
  );

  word_bit_shifter #(.WORD_W(WORD_W), .LEN_W(LEN_W)) i_shift (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .tick        (bclk_en & core_rst_n),
    .slot_start  (slot_start),
    .drive_zero  (drive_zero),
    .slot_len_m1 (slot_len_m1),
    .wr_valid    (wr_valid),
    .wr_data     (wr_data),
    .sdata       (sdata),
    .last_bit    (last_bit),
    .underrun    (underrun)
  );

  assign wr_ready = slot_start;
endmodule

// File: rtl/serial_frame_tx_chk.sv
module serial_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bclk_en,
  input logic fsync,
  input logic cfg_delay1,
  input logic wr_valid,
  input logic wr_ready,
  input logic sdata,
  input logic underrun
);
  // R2: serial line moves only on bit-clock ticks
  assert_sdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_en |=> $stable(sdata));

  // R8: a word is requested only on a tick
  assert_ready_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> bclk_en);

  // R9: underrun follows a request that found no word
  assert_underrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready && !wr_valid |=> underrun);

  // R9: an underrun slot starts with a zero bit
  assert_underrun_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !sdata);

  // R3: with one-bit delay the frame-sync tick drives zero
  assert_delay_slot_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_en && fsync && cfg_delay1 |=> !sdata);

  // R1: outputs quiet in reset
  always_comb begin
    if (!rst_n) assert_reset_quiet_R1: assert (!sdata && !underrun);
  end
endmodule

bind serial_frame_tx serial_frame_tx_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bclk_en    (bclk_en),
  .fsync      (fsync),
  .cfg_delay1 (cfg_delay1),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .sdata      (sdata),
  .underrun   (underrun)
);

// File: tb/test_serial_frame_tx.sv
module test_serial_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bclk_en, fsync, cfg_dual_phase, cfg_delay1;
  logic [3:0]  cfg_ph1_words_m1, cfg_ph2_words_m1, cfg_ph1_len_m1, cfg_ph2_len_m1;
  logic        wr_valid;
  logic [15:0] wr_data;
  logic        wr_ready, sdata, underrun;

  int nchk = 0;
  int nfail = 0;
  int wptr = 0;
  int navail = 0;
  logic [15:0] words [0:63];
  logic        exp_bits [0:255];
  logic        got_a [0:255];
  logic        got_b [0:255];
  int pops, uruns;

  always #2.5 clk = ~clk;

  serial_frame_tx i_serial_frame_tx (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .fsync(fsync),
    .cfg_dual_phase(cfg_dual_phase), .cfg_delay1(cfg_delay1),
    .cfg_ph1_words_m1(cfg_ph1_words_m1), .cfg_ph2_words_m1(cfg_ph2_words_m1),
    .cfg_ph1_len_m1(cfg_ph1_len_m1), .cfg_ph2_len_m1(cfg_ph2_len_m1),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .sdata(sdata), .underrun(underrun));

  initial begin
    #200000;
    nfail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic tick(input int t, input bit fs);
    bit take;
    @(negedge clk);
    bclk_en = 1'b1; fsync = fs;
    wr_valid = (wptr < navail);
    wr_data = words[wptr % 64];
    #1 take = wr_ready && wr_valid;
    if (wr_ready) pops++;
    @(posedge clk); #1;
    bclk_en = 1'b0; fsync = 1'b0; wr_valid = 1'b0;
    if (take) wptr++;
    @(negedge clk);
    got_a[t] = sdata;
    if (underrun) uruns++;
    @(negedge clk);
    got_b[t] = sdata;
  endtask

  function automatic void build_exp(input bit dual, input int n1, input int n2,
                                    input int l1, input int l2, input bit dly,
                                    input int base, input int avail);
    int pos, k;
    for (int i = 0; i < 256; i++) exp_bits[i] = 1'b0;
    pos = dly ? 1 : 0;
    k = 0;
    for (int ph = 0; ph < (dual ? 2 : 1); ph++) begin
      for (int w = 0; w < ((ph == 0) ? n1 : n2); w++) begin
        for (int b = ((ph == 0) ? l1 : l2) - 1; b >= 0; b--) begin
          exp_bits[pos] = (k < avail) ? words[base + k][b] : 1'b0;
          pos++;
        end
        k++;
      end
    end
  endfunction

  task automatic run(input bit dual, input int n1, input int n2, input int l1,
                     input int l2, input bit dly, input int avail, input int nt,
                     input int fs2, output int bad, output int unstable);
    int base;
    base = wptr;
    navail = wptr + avail;
    cfg_dual_phase = dual; cfg_delay1 = dly;
    cfg_ph1_words_m1 = 4'(n1 - 1); cfg_ph2_words_m1 = 4'(n2 - 1);
    cfg_ph1_len_m1 = 4'(l1 - 1); cfg_ph2_len_m1 = 4'(l2 - 1);
    build_exp(dual, n1, n2, l1, l2, dly, base, avail);
    pops = 0; uruns = 0;
    for (int t = 0; t < nt; t++) tick(t, (t == 0) || (t == fs2));
    bad = 0; unstable = 0;
    for (int t = 0; t < nt; t++) begin
      if (got_a[t] !== exp_bits[t]) bad++;
      if (got_a[t] !== got_b[t]) unstable++;
    end
  endtask

  task automatic t_reset;
    check(sdata == 1'b0, "R1 sdata after reset", sdata, 0);
    check(wr_ready == 1'b0, "R1 wr_ready after reset", wr_ready, 0);
    check(underrun == 1'b0, "R1 underrun after reset", underrun, 0);
  endtask

  task automatic t_idle;
    pops = 0;
    navail = wptr + 4;
    for (int t = 0; t < 8; t++) tick(t, 1'b0);
    for (int t = 0; t < 8; t++) check(got_a[t] == 1'b0, "R7 idle before fsync", got_a[t], 0);
    check(pops == 0, "R7 no request while idle", pops, 0);
  endtask

  task automatic t_i2s_stereo;
    int bad, uns;
    run(1, 1, 1, 16, 16, 1, 2, 40, -1, bad, uns);
    check(bad == 0, "R3 R6 I2S stereo bit stream", bad, 0);
    check(pops == 2, "R8 one word per slot stereo", pops, 2);
    check(uns == 0, "R2 sdata stable between ticks", uns, 0);
  endtask

  task automatic t_dspb_multi;
    int bad, uns;
    run(0, 3, 1, 16, 16, 0, 3, 56, -1, bad, uns);
    check(bad == 0, "R5 R3 DSP-B three words zero delay", bad, 0);
    check(pops == 3, "R5 R7 three words then no request", pops, 3);
  endtask

  task automatic t_dspa;
    int bad, uns;
    run(0, 2, 1, 16, 16, 1, 2, 40, -1, bad, uns);
    check(bad == 0, "R3 DSP-A one-bit delay", bad, 0);
    check(got_a[0] == 1'b0, "R3 fsync tick drives zero", got_a[0], 0);
  endtask

  task automatic t_mixed_len;
    int bad, uns;
    run(1, 2, 1, 8, 4, 0, 3, 28, -1, bad, uns);
    check(bad == 0, "R4 R6 per-phase lengths MSB first", bad, 0);
    check(pops == 3, "R6 words across both phases", pops, 3);
  endtask

  task automatic t_underrun;
    int bad, uns;
    run(0, 2, 1, 16, 16, 0, 0, 36, -1, bad, uns);
    check(bad == 0, "R9 underrun slots shift zero", bad, 0);
    check(uruns == 2, "R9 underrun pulses", uruns, 2);
  endtask

  task automatic t_resync;
    int bad, uns, base;
    base = wptr;
    run(0, 2, 1, 16, 16, 0, 3, 48, 10, bad, uns);
    for (int i = 0; i < 256; i++) exp_bits[i] = 1'b0;
    for (int t = 0; t < 10; t++) exp_bits[t] = words[base][15 - t];
    for (int t = 0; t < 16; t++) begin
      exp_bits[10 + t] = words[base + 1][15 - t];
      exp_bits[26 + t] = words[base + 2][15 - t];
    end
    bad = 0;
    for (int t = 0; t < 48; t++) if (got_a[t] !== exp_bits[t]) bad++;
    check(bad == 0, "R10 mid-frame fsync restarts frame", bad, 0);
    check(pops == 3, "R10 restart takes fresh words", pops, 3);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) words[i] = 16'(32'hA5C3 ^ (i * 32'h1357) ^ (i << 9));
    rst_n = 1'b0; bclk_en = 1'b0; fsync = 1'b0; wr_valid = 1'b0; wr_data = '0;
    cfg_dual_phase = 1'b0; cfg_delay1 = 1'b0;
    cfg_ph1_words_m1 = '0; cfg_ph2_words_m1 = '0;
    cfg_ph1_len_m1 = 4'd15; cfg_ph2_len_m1 = 4'd15;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset;
    t_idle;
    t_i2s_stereo;
    t_dspb_multi;
    t_dspa;
    t_mixed_len;
    t_underrun;
    t_resync;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule